// File: doc/BRIEF.md
# Protect-Steered Port Gate with Timed Programming Cycle

This block sits between four serial-bus protocol engines and three shared memory banks. A single protect input chooses the access mode. When it is high, only the write-capable port may reach the banks. When it is low, that port is shut out and the three read-only ports are opened, each working on its own. The protect input is brought into the clock domain through a short synchronizer. The enables follow the synchronized copy.

The block also times the internal programming cycle. The write engine raises a commit pulse when a page write closes with STOP. The pulse carries the bank code, the page number and a byte mask. While the timer runs, the block reports busy and refuses every acknowledge on every port, so a master can poll with the slave address until it is acknowledged again. Normal expiry emits an apply pulse, which tells the banks to store the staged bytes. If protect drops during the cycle, the cycle is aborted and a corrupt pulse is emitted instead, which tells the banks to fill the masked bytes with all-ones. Both outcomes raise a one-cycle done pulse.

Top module: `port_gate_wcycle`

## Requirements
- R1: With the synchronized protect high, `wport_en` is 1 and every bit of `rport_en` is 0. The enables follow a change on `wp_in` after SYNC_STAGES clock edges.
- R2: With the synchronized protect low (the reset state), `wport_en` is 0 and every bit of `rport_en` is 1. The read ports grant acknowledges independently, bit for bit.
- R3: A commit pulse is accepted only if all three of these hold: protect is high, the bank code is non-zero, and the block is idle. Bank code 0 means no bank, and codes 1, 2 and 3 select a bank. A refused commit leaves `busy` low and no done pulse follows.
- R4: An accepted commit holds `busy` high for exactly PROG_CYCLES clock cycles. In the cycle after the last one, `busy` is low, and `done` and `prog_apply` are high together for one cycle.
- R5: While `busy` is high, `ack_grant0` and all bits of `rd_ack_grant` are 0, whatever the requests.
- R6: If protect falls while busy, `busy` drops SYNC_STAGES+1 edges after `wp_in` falls, with a one-cycle `done` and `prog_corrupt`, and `prog_apply` stays 0.
- R7: `tgt_bank`, `tgt_page` and `tgt_mask` hold the accepted commit's fields for the whole cycle and at the outcome pulse. A commit arriving while busy changes neither these fields nor the cycle length.
- R8: A read port whose `rd_active` bit is high while its enable is low sees its `rd_drop` bit high from the next clock edge on. The bit returns to 0 one edge after `rd_active` falls.
- R9: When idle, an acknowledge request on an enabled port is granted in the same cycle, and a request on a disabled port is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_in | input | 1 | Protect / mode select, asynchronous |
| wr_commit | input | 1 | One-cycle commit of a closed page write |
| wr_bank | input | 2 | Bank code of the commit (0 = none) |
| wr_page | input | PAGE_AW | Page number of the commit |
| wr_mask | input | PAGE_BYTES | Bytes of the page touched by the write |
| ack_req0 | input | 1 | Write-port engine wants to acknowledge |
| rd_ack_req | input | N_RD | Read-port engines want to acknowledge |
| rd_active | input | N_RD | Read-port engines are mid-transaction |
| wport_en | output | 1 | Write port enabled |
| rport_en | output | N_RD | Read ports enabled |
| ack_grant0 | output | 1 | Acknowledge allowed on the write port |
| rd_ack_grant | output | N_RD | Acknowledge allowed on each read port |
| rd_drop | output | N_RD | Abandon the transaction and release the line |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-cycle pulse at the end of a cycle |
| prog_apply | output | 1 | One-cycle pulse: store the staged bytes |
| prog_corrupt | output | 1 | One-cycle pulse: fill masked bytes with ones |
| tgt_bank | output | 2 | Bank of the current or last cycle |
| tgt_page | output | PAGE_AW | Page of the current or last cycle |
| tgt_mask | output | PAGE_BYTES | Byte mask of the current or last cycle |

## Verification
The bench builds the block with PROG_CYCLES set to 20 instead of a full millisecond-scale count, so every completion, abort and polling case fits in a few hundred cycles. The bench counts the exact busy length for both the normal and the abort outcome. SYNC_STAGES stays at 2, which makes the protect-to-enable latency and the abort latency of three edges observable. Three read ports with an 8-byte page let the bench check the per-port independence of grants and drops, and that the mask is carried intact.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_A    = 2'd1,
    BANK_B    = 2'd2,
    BANK_C    = 2'd3
  } bank_sel_e;

  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_PROG = 1'b1
  } prog_state_e;

endpackage

// File: rtl/pgw_sync.sv
module pgw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pgw_port_gate.sv
module pgw_port_gate #(
  parameter int N_RD = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wp_ok,
  input  logic            busy,
  input  logic            ack_req0,
  input  logic [N_RD-1:0] rd_ack_req,
  input  logic [N_RD-1:0] rd_active,
  output logic            wport_en,
  output logic [N_RD-1:0] rport_en,
  output logic            ack_grant0,
  output logic [N_RD-1:0] rd_ack_grant,
  output logic [N_RD-1:0] rd_drop
);

  always_comb begin
    wport_en   = wp_ok;
    rport_en   = {N_RD{~wp_ok}};
    ack_grant0 = ack_req0 & wport_en & ~busy;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_RD; gi++) begin : g_rd
      logic drop_d;
      logic drop_q;

      always_comb begin
        rd_ack_grant[gi] = rd_ack_req[gi] & rport_en[gi] & ~busy;
        drop_d           = rd_active[gi] & ~rport_en[gi];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drop_q <= 1'b0;
        else        drop_q <= drop_d;
      end

      assign rd_drop[gi] = drop_q;

      AST_DROP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active[gi] && !rport_en[gi]) |=> rd_drop[gi]); // R8
      AST_NO_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active[gi] |=> !rd_drop[gi]); // R8
    end
  endgenerate

  AST_EXCLUSIVE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wport_en && (|rport_en))); // R1
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ack_grant0 && (rd_ack_grant == '0))); // R5

endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer
  import pgw_pkg::*;
#(
  parameter int PROG_CYCLES = 500000,
  parameter int PAGE_AW     = 5,
  parameter int PAGE_BYTES  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wp_ok,
  input  logic                  commit,
  input  logic [1:0]            commit_bank,
  input  logic [PAGE_AW-1:0]    commit_page,
  input  logic [PAGE_BYTES-1:0] commit_mask,
  output logic                  busy,
  output logic                  done,
  output logic                  apply,
  output logic                  corrupt,
  output logic [1:0]            tgt_bank,
  output logic [PAGE_AW-1:0]    tgt_page,
  output logic [PAGE_BYTES-1:0] tgt_mask
);

  localparam int CW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  prog_state_e           state_q, state_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  done_q, done_d;
  logic                  apply_q, apply_d;
  logic                  corrupt_q, corrupt_d;
  logic [1:0]            bank_q;
  logic [PAGE_AW-1:0]    page_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic                  accept;
  logic                  tgt_en;

  always_comb begin
    accept    = (state_q == PS_IDLE) && commit && wp_ok &&
                (bank_sel_e'(commit_bank) != BANK_NONE);
    tgt_en    = accept;
    state_d   = state_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    apply_d   = 1'b0;
    corrupt_d = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (accept) begin
          state_d = PS_PROG;
          cnt_d   = LAST;
        end
      end
      PS_PROG: begin
        if (!wp_ok) begin
          state_d   = PS_IDLE;
          done_d    = 1'b1;
          corrupt_d = 1'b1;
        end else if (cnt_q == '0) begin
          state_d = PS_IDLE;
          done_d  = 1'b1;
          apply_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_IDLE;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      apply_q   <= 1'b0;
      corrupt_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      done_q    <= done_d;
      apply_q   <= apply_d;
      corrupt_q <= corrupt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      page_q <= '0;
      mask_q <= '0;
    end else if (tgt_en) begin
      bank_q <= commit_bank;
      page_q <= commit_page;
      mask_q <= commit_mask;
    end
  end

  assign busy     = (state_q == PS_PROG);
  assign done     = done_q;
  assign apply    = apply_q;
  assign corrupt  = corrupt_q;
  assign tgt_bank = bank_q;
  assign tgt_page = page_q;
  assign tgt_mask = mask_q;

  AST_ABORT_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wp_ok) |=> (!busy && corrupt && !apply)); // R6
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply && corrupt)); // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R4
  AST_REFUSE_LOW_WP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wp_ok) |=> !busy); // R3
  AST_TGT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(tgt_bank) && $stable(tgt_page) && $stable(tgt_mask))); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4

endmodule

// File: rtl/port_gate_wcycle.sv
module port_gate_wcycle #(
  parameter int N_RD        = 3,
  parameter int PAGE_AW     = 5,
  parameter int PAGE_BYTES  = 8,
  parameter int PROG_CYCLES = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wp_in,
  input  logic                  wr_commit,
  input  logic [1:0]            wr_bank,
  input  logic [PAGE_AW-1:0]    wr_page,
  input  logic [PAGE_BYTES-1:0] wr_mask,
  input  logic                  ack_req0,
  input  logic [N_RD-1:0]       rd_ack_req,
  input  logic [N_RD-1:0]       rd_active,
  output logic                  wport_en,
  output logic [N_RD-1:0]       rport_en,
  output logic                  ack_grant0,
  output logic [N_RD-1:0]       rd_ack_grant,
  output logic [N_RD-1:0]       rd_drop,
  output logic                  busy,
  output logic                  done,
  output logic                  prog_apply,
  output logic                  prog_corrupt,
  output logic [1:0]            tgt_bank,
  output logic [PAGE_AW-1:0]    tgt_page,
  output logic [PAGE_BYTES-1:0] tgt_mask
);

  logic wp_ok;

  pgw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (wp_in),
    .q     (wp_ok)
  );

  pgw_prog_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .PAGE_AW     (PAGE_AW),
    .PAGE_BYTES  (PAGE_BYTES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_ok       (wp_ok),
    .commit      (wr_commit),
    .commit_bank (wr_bank),
    .commit_page (wr_page),
    .commit_mask (wr_mask),
    .busy        (busy),
    .done        (done),
    .apply       (prog_apply),
    .corrupt     (prog_corrupt),
    .tgt_bank    (tgt_bank),
    .tgt_page    (tgt_page),
    .tgt_mask    (tgt_mask)
  );

  pgw_port_gate #(.N_RD(N_RD)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp_ok        (wp_ok),
    .busy         (busy),
    .ack_req0     (ack_req0),
    .rd_ack_req   (rd_ack_req),
    .rd_active    (rd_active),
    .wport_en     (wport_en),
    .rport_en     (rport_en),
    .ack_grant0   (ack_grant0),
    .rd_ack_grant (rd_ack_grant),
    .rd_drop      (rd_drop)
  );

  AST_DONE_HAS_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prog_apply || prog_corrupt)); // R4

endmodule

// File: tb/port_gate_wcycle_test.sv
`timescale 1ns/1ps
module port_gate_wcycle_test;

  localparam int N_RD  = 3;
  localparam int AW    = 5;
  localparam int NB    = 8;
  localparam int PROG  = 20;
  localparam int SYNC  = 2;

  logic          clk;
  logic          rst_n;
  logic          wp_in;
  logic          wr_commit;
  logic [1:0]    wr_bank;
  logic [AW-1:0] wr_page;
  logic [NB-1:0] wr_mask;
  logic          ack_req0;
  logic [N_RD-1:0] rd_ack_req;
  logic [N_RD-1:0] rd_active;
  logic          wport_en;
  logic [N_RD-1:0] rport_en;
  logic          ack_grant0;
  logic [N_RD-1:0] rd_ack_grant;
  logic [N_RD-1:0] rd_drop;
  logic          busy, done, prog_apply, prog_corrupt;
  logic [1:0]    tgt_bank;
  logic [AW-1:0] tgt_page;
  logic [NB-1:0] tgt_mask;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  port_gate_wcycle #(
    .N_RD(N_RD), .PAGE_AW(AW), .PAGE_BYTES(NB),
    .PROG_CYCLES(PROG), .SYNC_STAGES(SYNC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wp_in(wp_in),
    .wr_commit(wr_commit), .wr_bank(wr_bank), .wr_page(wr_page), .wr_mask(wr_mask),
    .ack_req0(ack_req0), .rd_ack_req(rd_ack_req), .rd_active(rd_active),
    .wport_en(wport_en), .rport_en(rport_en), .ack_grant0(ack_grant0),
    .rd_ack_grant(rd_ack_grant), .rd_drop(rd_drop), .busy(busy), .done(done),
    .prog_apply(prog_apply), .prog_corrupt(prog_corrupt),
    .tgt_bank(tgt_bank), .tgt_page(tgt_page), .tgt_mask(tgt_mask)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk);
    wp_in = v;
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic commit(input logic [1:0] b, input logic [AW-1:0] p, input logic [NB-1:0] m);
    @(negedge clk);
    wr_commit = 1'b1; wr_bank = b; wr_page = p; wr_mask = m;
    @(negedge clk);
    wr_commit = 1'b0;
  endtask

  task automatic t_reset;
    chk(wport_en == 1'b0, "R2", "reset wport_en", int'(wport_en), 0);
    chk(rport_en == 3'b111, "R2", "reset rport_en", int'(rport_en), 7);
    chk(busy == 1'b0 && done == 1'b0, "R4", "reset busy/done", int'({busy, done}), 0);
  endtask

  task automatic t_read_mode;
    @(negedge clk);
    rd_ack_req = 3'b101; ack_req0 = 1'b1;
    #1;
    chk(rd_ack_grant == 3'b101, "R2", "independent read grants", int'(rd_ack_grant), 5);
    chk(ack_grant0 == 1'b0, "R9", "write port refused in read mode", int'(ack_grant0), 0);
    rd_ack_req = '0; ack_req0 = 1'b0;
  endtask

  task automatic t_protect_mode;
    @(negedge clk);
    wp_in = 1'b1;
    repeat (SYNC - 1) @(negedge clk);
    chk(wport_en == 1'b0, "R1", "enable not yet switched", int'(wport_en), 0);
    @(negedge clk);
    chk(wport_en == 1'b1, "R1", "wport_en after sync", int'(wport_en), 1);
    chk(rport_en == 3'b000, "R1", "read ports closed", int'(rport_en), 0);
    rd_ack_req = 3'b111; ack_req0 = 1'b1;
    #1;
    chk(rd_ack_grant == 3'b000, "R1", "read ports no ack", int'(rd_ack_grant), 0);
    chk(ack_grant0 == 1'b1, "R9", "idle write ack granted", int'(ack_grant0), 1);
    rd_ack_req = '0; ack_req0 = 1'b0;
  endtask

  task automatic t_normal_write;
    int n = 0;
    bit leaked = 0;
    bit tgt_bad = 0;
    commit(2'd2, 5'd5, 8'h3C);
    ack_req0 = 1'b1; rd_ack_req = 3'b111;
    while (busy && n < 1000) begin
      n++;
      if (ack_grant0 || rd_ack_grant != 0) leaked = 1;
      if (tgt_bank != 2'd2 || tgt_page != 5'd5 || tgt_mask != 8'h3C) tgt_bad = 1;
      @(negedge clk);
    end
    chk(n == PROG, "R4", "busy length", n, PROG);
    chk(!leaked, "R5", "no ack while busy", int'(leaked), 0);
    chk(!tgt_bad, "R7", "target held during cycle", int'(tgt_bad), 0);
    chk(done && prog_apply && !prog_corrupt, "R4", "done+apply pulse",
        int'({done, prog_apply, prog_corrupt}), 6);
    chk(ack_grant0 == 1'b1, "R9", "ack returns after cycle", int'(ack_grant0), 1);
    ack_req0 = 1'b0; rd_ack_req = '0;
    @(negedge clk);
    chk(!done && !prog_apply, "R4", "pulse lasts one cycle", int'({done, prog_apply}), 0);
  endtask

  task automatic t_commit_while_busy;
    int n = 0;
    commit(2'd1, 5'd3, 8'h01);
    repeat (4) begin n++; @(negedge clk); end
    wr_commit = 1'b1; wr_bank = 2'd3; wr_page = 5'd7; wr_mask = 8'hFF;
    @(negedge clk); n++;
    wr_commit = 1'b0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == PROG, "R7", "second commit does not restart", n, PROG);
    chk(tgt_page == 5'd3 && tgt_mask == 8'h01 && tgt_bank == 2'd1, "R7",
        "target unchanged by busy commit", int'(tgt_page), 3);
    chk(prog_apply == 1'b1, "R4", "apply at end", int'(prog_apply), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R7", "no follow-on cycle", int'(busy), 0);
  endtask

  task automatic t_refusals;
    bit saw = 0;
    commit(2'd0, 5'd9, 8'hAA);
    repeat (3) begin
      if (busy || done) saw = 1;
      @(negedge clk);
    end
    chk(!saw, "R3", "bank code 0 refused", int'(saw), 0);
    set_wp(1'b0);
    saw = 0;
    commit(2'd1, 5'd9, 8'hAA);
    repeat (3) begin
      if (busy || done) saw = 1;
      @(negedge clk);
    end
    chk(!saw, "R3", "commit with protect low refused", int'(saw), 0);
    set_wp(1'b1);
  endtask

  task automatic t_abort;
    int n = 0;
    commit(2'd3, 5'd17, 8'hF0);
    repeat (5) @(negedge clk);
    wp_in = 1'b0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == SYNC + 1, "R6", "abort latency", n, SYNC + 1);
    chk(done && prog_corrupt && !prog_apply, "R6", "corrupt pulse",
        int'({done, prog_apply, prog_corrupt}), 5);
    chk(tgt_mask == 8'hF0 && tgt_page == 5'd17, "R7", "mask at abort", int'(tgt_mask), 240);
    @(negedge clk);
    chk(!prog_corrupt && !done, "R6", "corrupt one cycle", int'({done, prog_corrupt}), 0);
  endtask

  task automatic t_drop;
    @(negedge clk);
    rd_active = 3'b010;
    @(negedge clk);
    chk(rd_drop == 3'b000, "R8", "no drop while enabled", int'(rd_drop), 0);
    wp_in = 1'b1;
    repeat (SYNC) @(negedge clk);
    chk(rd_drop == 3'b000, "R8", "drop not before enable loss", int'(rd_drop), 0);
    @(negedge clk);
    chk(rd_drop == 3'b010, "R8", "drop on next clock", int'(rd_drop), 2);
    rd_active = 3'b000;
    @(negedge clk);
    chk(rd_drop == 3'b000, "R8", "drop clears", int'(rd_drop), 0);
  endtask

  initial begin
    rst_n = 1'b0; wp_in = 1'b0; wr_commit = 1'b0; wr_bank = '0; wr_page = '0;
    wr_mask = '0; ack_req0 = 1'b0; rd_ack_req = '0; rd_active = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_mode();
    t_protect_mode();
    t_normal_write();
    t_commit_while_busy();
    t_refusals();
    t_abort();
    set_wp(1'b0);
    t_drop();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule